// File: doc/BRIEF.md
# Two-Table Butterfly Bit Permuter

This block pushes a 64-bit word through a six-row butterfly network. In each row, every bit is paired with the bit whose index differs from its own by that row's step. The new value of the bit is taken from a small two-input truth table, indexed by the bit itself and its partner. The row is not hard-wired to swap the pair.

Each row has two 4-bit tables. The table a bit uses depends on whether it lies in the lower or the upper half of its chunk. With the right tables the network gives plain generalised reverse, OR-combine, full bit reversal and many other bit shufflers.

A zero-source flag replaces the data word with zero. The tables alone then produce regular constant patterns. The low bits of a control word pick which rows are active. An optional output register, selected by a parameter, gives a fixed one-cycle latency.

Top module: `grlut_unit`

## Requirements
- R1: Only the low log2(W) bits of `ctrl` (bits 5:0 for W=64) form the stage-enable amount. All higher `ctrl` bits have no effect on `result`.
- R2: Row k (step = 1<<k) is active only when bit k of the amount is set. With amount 0, `result` equals the source word.
- R3: Active rows are applied in ascending step order: 1, 2, 4, 8, 16, 32. Each row acts on the output of the row before it.
- R4: In an active row, output bit j = T[{x[j^step], x[j]}], where bit 0 of the 4-bit table T is its least significant bit. T is `tables[3:0]` when (j & step) == 0 and `tables[7:4]` otherwise.
- R5: When `zero_src` is 1 the source word is all zeros, whatever `data_in` holds. With both tables 0 the result is then 0.
- R6: With `tables` = 8'hCC (both tables = 4'b1100, "take partner"), `result` equals the generalised reverse of `data_in`. For every amount, each enabled row exchanges the bit pairs that lie `step` apart.
- R7: With `tables` = 8'hEE (both tables = 4'b1110, OR), `result` equals the OR-combine. Each enabled row ORs every bit with its partner.
- R8: With `tables` = 8'hCC and amount 63, `result` is `data_in` with its 64 bits in reverse order.
- R9: With PIPE=1, `result` and `out_valid` are updated on the clock edge that samples `in_valid` = 1, and `out_valid` goes low on the edge after `in_valid` is 0. Reset (synchronous, active high) clears both outputs to 0.
- R10: With PIPE=1, `result` holds its value over every cycle in which `in_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| data_in | input | 64 | Source word |
| zero_src | input | 1 | Replace source word with zero |
| ctrl | input | 64 | Control word; low 6 bits enable rows |
| tables | input | 8 | [3:0] lower-half table, [7:4] upper-half table |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Permuted / combined word |

## Verification
The take-partner and OR tables are swept over all 64 amounts against shift-and-mask models of reverse and OR-combine. These sweeps show whether the right rows fire and whether the partner distance is right. All 256 table values are run on mixed data at several amounts, including single rows, the ascending-order pair 1+2, and all rows. This catches swapped table halves, a reversed index order and a wrong row order. Further cases use zero-source with constant tables, vary the control bits above bit 5, and drop `in_valid` to confirm the output holds. Together these show that the zero source forces the data to zero, that the upper control bits are ignored, and that the register holds while idle.

// File: rtl/grlut_pkg.sv
package grlut_pkg;

    localparam int unsigned DATA_W = 64;

    typedef logic [3:0] lut2_t;

    typedef struct packed {
        lut2_t hi;
        lut2_t lo;
    } lut_pair_t;

    function automatic logic lut2_eval(lut2_t tbl, logic self_b, logic mate_b);
        return tbl[{mate_b, self_b}];
    endfunction

endpackage

// File: rtl/grlut_stage.sv
module grlut_stage
    import grlut_pkg::*;
#(
    parameter int unsigned W    = 64,
    parameter int unsigned STEP = 1
) (
    input  logic         en,
    input  lut_pair_t    luts,
    input  logic [W-1:0] x_in,
    output logic [W-1:0] x_out
);
    for (genvar j = 0; j < W; j++) begin : g_bit
        localparam int unsigned MATE  = j ^ STEP;
        localparam bit          UPPER = (j & STEP) != 0;
        logic nb;
        if (UPPER) begin : g_hi
            assign nb = lut2_eval(luts.hi, x_in[j], x_in[MATE]);
        end else begin : g_lo
            assign nb = lut2_eval(luts.lo, x_in[j], x_in[MATE]);
        end
        assign x_out[j] = en ? nb : x_in[j];
    end
endmodule

// File: rtl/grlut_net.sv
module grlut_net
    import grlut_pkg::*;
#(
    parameter int unsigned W   = 64,
    parameter int unsigned LOG = $clog2(W)
) (
    input  logic [LOG-1:0] amount,
    input  lut_pair_t      luts,
    input  logic [W-1:0]   src,
    output logic [W-1:0]   dst
);
    logic [W-1:0] row [LOG+1];
    assign row[0] = src;

    for (genvar k = 0; k < LOG; k++) begin : g_row
        grlut_stage #(.W(W), .STEP(1 << k)) u_stage (
            .en   (amount[k]),
            .luts (luts),
            .x_in (row[k]),
            .x_out(row[k+1])
        );
    end

    assign dst = row[LOG];
endmodule

// File: rtl/grlut_unit.sv
module grlut_unit
    import grlut_pkg::*;
#(
    parameter int unsigned W    = DATA_W,
    parameter bit          PIPE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] data_in,
    input  logic         zero_src,
    input  logic [W-1:0] ctrl,
    input  logic [7:0]   tables,
    output logic         out_valid,
    output logic [W-1:0] result
);
    localparam int unsigned LOG = $clog2(W);

    logic [W-1:0]   src;
    logic [W-1:0]   net_out;
    logic [LOG-1:0] amount;
    lut_pair_t      luts;

    assign src    = zero_src ? '0 : data_in;
    assign amount = ctrl[LOG-1:0];
    assign luts   = lut_pair_t'(tables);

    grlut_net #(.W(W), .LOG(LOG)) u_net (
        .amount(amount),
        .luts  (luts),
        .src   (src),
        .dst   (net_out)
    );

    if (PIPE) begin : g_pipe
        logic [W-1:0] res_q;
        logic         vld_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                res_q <= '0;
                vld_q <= 1'b0;
            end else begin
                vld_q <= in_valid;
                if (in_valid) res_q <= net_out;
            end
        end
        assign result    = res_q;
        assign out_valid = vld_q;
    end else begin : g_comb
        assign result    = net_out;
        assign out_valid = in_valid;
    end
endmodule

// File: rtl/grlut_unit_chk.sv
module grlut_unit_chk #(
    parameter int unsigned W    = 64,
    parameter bit          PIPE = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [W-1:0] data_in,
    input logic         zero_src,
    input logic [W-1:0] ctrl,
    input logic [7:0]   tables,
    input logic         out_valid,
    input logic [W-1:0] result
);
    localparam int unsigned LOG = $clog2(W);

    function automatic logic [W-1:0] flip(logic [W-1:0] v);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = v[W-1-i];
        return r;
    endfunction

    if (PIPE) begin : g_chk
        // R9: output valid follows the sampled input valid
        a_r9_valid_rise: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
        a_r9_valid_fall: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);
        // R10: idle cycles leave the result untouched
        a_r10_hold: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> $stable(result));
        // R2: no active rows passes the source word through
        a_r2_bypass: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !zero_src && ctrl[LOG-1:0] == '0)
            |=> result == $past(data_in));
        // R5: zero source with all-zero tables yields zero
        a_r5_zero: assert property (@(posedge clk) disable iff (rst)
            (in_valid && zero_src && tables == 8'h00) |=> result == '0);
        // R8: full amount with take-partner tables reverses the word
        a_r8_reverse: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !zero_src && tables == 8'hCC && (&ctrl[LOG-1:0]))
            |=> result == flip($past(data_in)));
    end
endmodule

bind grlut_unit grlut_unit_chk #(.W(W), .PIPE(PIPE)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .data_in(data_in),
    .zero_src(zero_src), .ctrl(ctrl), .tables(tables),
    .out_valid(out_valid), .result(result)
);

// File: tb/grlut_unit_test.sv
`timescale 1ns/1ps
module grlut_unit_test;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] data_in = '0;
    logic         zero_src = 1'b0;
    logic [W-1:0] ctrl = '0;
    logic [7:0]   tables = '0;
    logic         out_valid;
    logic [W-1:0] result;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    grlut_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .data_in(data_in),
        .zero_src(zero_src), .ctrl(ctrl), .tables(tables),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [W-1:0] low_mask(int s);
        logic [W-1:0] m = '0;
        for (int j = 0; j < W; j++) if ((j & s) == 0) m[j] = 1'b1;
        return m;
    endfunction

    function automatic logic [W-1:0] ref_grev(logic [W-1:0] x, int amt);
        for (int k = 0; k < 6; k++) begin
            int s = 1 << k;
            logic [W-1:0] m = low_mask(s);
            if (amt[k]) x = ((x & m) << s) | ((x & ~m) >> s);
        end
        return x;
    endfunction

    function automatic logic [W-1:0] ref_gorc(logic [W-1:0] x, int amt);
        for (int k = 0; k < 6; k++) begin
            int s = 1 << k;
            logic [W-1:0] m = low_mask(s);
            if (amt[k]) x = x | ((x & m) << s) | ((x & ~m) >> s);
        end
        return x;
    endfunction

    function automatic logic [W-1:0] ref_lut(logic [W-1:0] x, int amt, logic [7:0] t);
        for (int k = 0; k < 6; k++) begin
            int s = 1 << k;
            logic [W-1:0] y;
            if (amt[k]) begin
                for (int j = 0; j < W; j++) begin
                    int idx = 2 * int'(x[j ^ s]) + int'(x[j]);
                    if ((j & s) == 0) y[j] = t[idx];
                    else              y[j] = t[4 + idx];
                end
                x = y;
            end
        end
        return x;
    endfunction

    function automatic logic [W-1:0] ref_flip(logic [W-1:0] v);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = v[W-1-i];
        return r;
    endfunction

    task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(string req, logic [W-1:0] d, logic z,
                         logic [W-1:0] c, logic [7:0] t, logic [W-1:0] exp);
        @(negedge clk);
        data_in = d; zero_src = z; ctrl = c; tables = t; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, result, exp);
        check({req, " valid"}, {63'd0, out_valid}, 64'd1);
    endtask

    logic [W-1:0] pats [4];

    initial begin
        pats[0] = 64'h0123_4567_89AB_CDEF;
        pats[1] = 64'h8000_0000_0000_0001;
        pats[2] = 64'hDEAD_BEEF_F00D_CAFE;
        pats[3] = 64'h0000_0000_0000_0010;

        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset result", result, '0);
        check("R9 reset valid", {63'd0, out_valid}, '0);
        rst = 1'b0;

        // R6 / R2: take-partner tables over every amount
        for (int p = 0; p < 4; p++)
            for (int a = 0; a < 64; a++)
                apply("R6 grev", pats[p], 1'b0, 64'(a), 8'hCC, ref_grev(pats[p], a));

        // R7: OR tables over every amount
        for (int p = 0; p < 4; p++)
            for (int a = 0; a < 64; a++)
                apply("R7 gorc", pats[p], 1'b0, 64'(a), 8'hEE, ref_gorc(pats[p], a));

        // R8: full reversal
        for (int p = 0; p < 4; p++)
            apply("R8 reverse", pats[p], 1'b0, 64'd63, 8'hCC, ref_flip(pats[p]));

        // R4 / R3: every table value, single rows, ordered pair, all rows
        for (int t = 0; t < 256; t++)
            foreach (pats[p])
                for (int ai = 0; ai < 9; ai++) begin
                    int amts [9] = '{0, 1, 2, 3, 4, 8, 16, 32, 63};
                    apply("R4 R3 lut", pats[p], 1'b0, 64'(amts[ai]), 8'(t),
                          ref_lut(pats[p], amts[ai], 8'(t)));
                end

        // R5: zero source, tables alone shape the constant
        for (int t = 0; t < 256; t += 17)
            for (int a = 0; a < 64; a += 7)
                apply("R5 zero src", pats[2], 1'b1, 64'(a), 8'(t), ref_lut('0, a, 8'(t)));
        apply("R5 zero const", '1, 1'b1, 64'd63, 8'h00, '0);

        // R1: upper control bits ignored
        for (int a = 0; a < 64; a += 5)
            apply("R1 upper ctrl", pats[0], 1'b0, {58'h2AB_CDEF_1234_567, 6'(a)}, 8'h96,
                  ref_lut(pats[0], a, 8'h96));

        // R10 / R9: idle cycles hold the result, valid drops
        apply("R10 setup", pats[3], 1'b0, 64'd5, 8'hCC, ref_grev(pats[3], 5));
        @(negedge clk);
        data_in = pats[0]; ctrl = 64'd63; tables = 8'h11;
        repeat (3) @(negedge clk);
        check("R10 hold", result, ref_grev(pats[3], 5));
        check("R9 valid low", {63'd0, out_valid}, '0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule